// File: doc/BRIEF.md
# Stereo Audio FIFO Status Controller

This block buffers audio samples between a host and a stereo serial audio port. It holds four separate sample queues: left transmit, right transmit, left receive and right receive. The host fills the transmit queues and drains the receive queues. The serial side works the other way round: it drains the transmit queues and fills the receive queues. The serial shifter and the frame timing sit outside the block and appear here only as one-cycle strobes.

From the fill level of each queue the block derives several outputs. Each queue raises a service request against a threshold, and the threshold is asymmetric: transmit queues ask for data when they run low, and receive queues ask to be drained when they run high. The block also sets sticky error flags when the serial side pops an empty queue or pushes into a full one. Transmit queues report not-full and receive queues report not-empty. All of these are packed into one 12-bit status word. A single interrupt line combines the service requests, each gated by its own mask bit, with the error flags, which are never masked. Clearing the interface enable forces every service request low and empties every queue.

Top module: `audio_fifo_status`

## Requirements
- R1: A receive service request (status bit 2 left, bit 3 right) is 1 exactly when the interface is enabled and its queue holds 6 or more samples. It is 0 at 5 or fewer.
- R2: A transmit service request (status bit 0 left, bit 1 right) is 1 exactly when the interface is enabled and its queue holds 4 or fewer samples.
- R3: While `ifEnable` is 0, status bits 3:0 all read 0 in the same cycle, whatever the fill levels.
- R4: A serial pop from an empty transmit queue while enabled sets that queue's underrun flag (status bit 4 left, bit 5 right) at the next clock edge. `serTxData` reads zero for that channel, and the queue is left unchanged.
- R5: A serial push into a full receive queue while enabled sets that queue's overrun flag (status bit 6 left, bit 7 right) at the next clock edge, and the incoming sample is dropped.
- R6: An error flag stays set until a 1 arrives on the `errClear` bit at its position (bit 0 maps to status bit 4, up to bit 3 mapping to status bit 7). If a new error and a clear arrive in the same cycle, the flag ends up set.
- R7: `irq` is the OR of every service request ANDed with its `maskBits` bit (mask bit n gates status bit n), ORed with all four error flags.
- R8: The transmit not-full flags (status bit 8 left, bit 9 right) are 0 only when the queue holds 12 samples. The receive not-empty flags (status bit 10 left, bit 11 right) are 1 whenever the queue holds at least one sample.
- R9: Strobes on one channel or one direction never change the queue contents or flags of another queue.
- R10: When `ifEnable` is 0 at a clock edge, all four queues are empty after that edge. Push and pop strobes made while disabled have no effect and set no error flags.
- R11: Each queue holds 12 samples of 16 bits in first-in first-out order. A host push into a full transmit queue is dropped. A host pop from an empty receive queue reads zero, changes nothing and sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifEnable | input | 1 | Interface enable |
| hostTxPush | input | 2 | Host push strobes into the transmit queues (bit 0 left, bit 1 right) |
| hostTxData | input | 32 | Host transmit samples (bits 15:0 left, 31:16 right) |
| hostRxPop | input | 2 | Host pop strobes from the receive queues |
| hostRxData | output | 32 | Head samples of the receive queues, zero when empty |
| serTxPop | input | 2 | Serial-side pop strobes from the transmit queues |
| serTxData | output | 32 | Head samples of the transmit queues, zero when empty |
| serRxPush | input | 2 | Serial-side push strobes into the receive queues |
| serRxData | input | 32 | Serial-side receive samples |
| maskBits | input | 4 | Interrupt enables for the service requests (status bits 3:0) |
| errClear | input | 4 | Write-one-to-clear strobes for the error flags (status bits 7:4) |
| status | output | 12 | Packed status word |
| irq | output | 1 | Combined interrupt |

## Verification
Fill levels and error flags are registered, and everything else is combinational on top of them. A strobe held across one rising edge therefore shows its effect on `status` and `irq` right after that edge, which is zero extra cycles of latency. Changes to `ifEnable` and `maskBits` reach the requests and the interrupt within the same cycle. Head data is visible before the pop that consumes it. The bench drives every input on the falling edge and samples one time unit later. For head data it checks while the pop strobe is still held, and for registered effects it checks at the falling edge that follows the capturing rising edge.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int NUM_Q = 4;
  // queue indices: transmit first, then receive; left before right
  localparam int Q_TXL = 0;
  localparam int Q_TXR = 1;
  localparam int Q_RXL = 2;
  localparam int Q_RXR = 3;

  typedef struct packed {
    logic [NUM_Q-1:0] push;
    logic [NUM_Q-1:0] pop;
    logic             flush;
  } q_ctl_t;
endpackage

// File: rtl/afs_queue.sv
module afs_queue #(
  parameter int DEPTH = 12,
  parameter int WIDTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rdPtr];
endmodule

// File: rtl/afs_datapath.sv
module afs_datapath
  import afs_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int WIDTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  q_ctl_t                      ctl,
  input  logic [NUM_Q-1:0][WIDTH-1:0] dinArr,
  output logic [NUM_Q-1:0][WIDTH-1:0] doutArr,
  output logic [NUM_Q-1:0][CW-1:0]    countArr
);
  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic [WIDTH-1:0] head;
    afs_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_queue (
      .clk   (clk),
      .rstN  (rstN),
      .flush (ctl.flush),
      .push  (ctl.push[q]),
      .pop   (ctl.pop[q]),
      .din   (dinArr[q]),
      .head  (head),
      .count (countArr[q])
    );
    // an empty queue presents zero rather than stale storage
    assign doutArr[q] = (countArr[q] != '0) ? head : '0;
  end
endmodule

// File: rtl/afs_ctrl.sv
module afs_ctrl
  import afs_pkg::*;
#(
  parameter int DEPTH   = 12,
  parameter int TX_LOW  = 4,
  parameter int RX_HIGH = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ifEnable,
  input  logic [1:0]               hostTxPush,
  input  logic [1:0]               hostRxPop,
  input  logic [1:0]               serTxPop,
  input  logic [1:0]               serRxPush,
  input  logic [3:0]               maskBits,
  input  logic [3:0]               errClear,
  input  logic [NUM_Q-1:0][CW-1:0] countArr,
  output q_ctl_t                   ctl,
  output logic [11:0]              status,
  output logic                     irq
);
  logic [NUM_Q-1:0] isFull, isEmpty, wantPush, wantPop;
  logic [1:0] txReq, rxReq;
  logic [3:0] errFlags, errHit;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_lvl
    assign isFull[q]  = (countArr[q] == CW'(DEPTH));
    assign isEmpty[q] = (countArr[q] == '0);
  end

  for (genvar c = 0; c < 2; c++) begin : g_req
    assign txReq[c] = ifEnable && (countArr[Q_TXL + c] <= CW'(TX_LOW));
    assign rxReq[c] = ifEnable && (countArr[Q_RXL + c] >= CW'(RX_HIGH));
  end

  assign wantPush = {serRxPush, hostTxPush};
  assign wantPop  = {hostRxPop, serTxPop};

  always_comb begin
    ctl.push  = wantPush & ~isFull  & {NUM_Q{ifEnable}};
    ctl.pop   = wantPop  & ~isEmpty & {NUM_Q{ifEnable}};
    ctl.flush = !ifEnable;
  end

  // error bits: 0/1 underrun left/right, 2/3 overrun left/right
  assign errHit = {serRxPush & isFull[Q_RXR:Q_RXL],
                   serTxPop  & isEmpty[Q_TXR:Q_TXL]} & {4{ifEnable}};

  always_ff @(posedge clk) begin
    if (!rstN) errFlags <= '0;
    else       errFlags <= (errFlags & ~errClear) | errHit;
  end

  assign status = {~isEmpty[Q_RXR:Q_RXL], ~isFull[Q_TXR:Q_TXL],
                   errFlags, rxReq, txReq};
  assign irq = (|({rxReq, txReq} & maskBits)) | (|errFlags);
endmodule

// File: rtl/audio_fifo_status.sv
module audio_fifo_status
  import afs_pkg::*;
#(
  parameter int DEPTH   = 12,
  parameter int WIDTH   = 16,
  parameter int TX_LOW  = 4,
  parameter int RX_HIGH = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ifEnable,
  input  logic [1:0]         hostTxPush,
  input  logic [2*WIDTH-1:0] hostTxData,
  input  logic [1:0]         hostRxPop,
  output logic [2*WIDTH-1:0] hostRxData,
  input  logic [1:0]         serTxPop,
  output logic [2*WIDTH-1:0] serTxData,
  input  logic [1:0]         serRxPush,
  input  logic [2*WIDTH-1:0] serRxData,
  input  logic [3:0]         maskBits,
  input  logic [3:0]         errClear,
  output logic [11:0]        status,
  output logic               irq
);
  localparam int CW = $clog2(DEPTH + 1);

  q_ctl_t                      qCtl;
  logic [NUM_Q-1:0][CW-1:0]    fifoCount;
  logic [NUM_Q-1:0][WIDTH-1:0] qDin, qDout;

  assign qDin       = {serRxData, hostTxData};
  assign serTxData  = {qDout[Q_TXR], qDout[Q_TXL]};
  assign hostRxData = {qDout[Q_RXR], qDout[Q_RXL]};

  afs_ctrl #(.DEPTH(DEPTH), .TX_LOW(TX_LOW), .RX_HIGH(RX_HIGH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ifEnable   (ifEnable),
    .hostTxPush (hostTxPush),
    .hostRxPop  (hostRxPop),
    .serTxPop   (serTxPop),
    .serRxPush  (serRxPush),
    .maskBits   (maskBits),
    .errClear   (errClear),
    .countArr   (fifoCount),
    .ctl        (qCtl),
    .status     (status),
    .irq        (irq)
  );

  afs_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (qCtl),
    .dinArr   (qDin),
    .doutArr  (qDout),
    .countArr (fifoCount)
  );
endmodule

// File: rtl/audio_fifo_status_chk.sv
module audio_fifo_status_chk #(
  parameter int DEPTH = 12,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             ifEnable,
  input logic [1:0]       serTxPop,
  input logic [1:0]       serRxPush,
  input logic [3:0]       errClear,
  input logic [11:0]      status,
  input logic             irq,
  input logic [3:0][CW-1:0] occ
);
  // R3: disabled interface silences every service request
  a_r3_req_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |-> (status[3:0] == 4'b0));

  // R4: serial pop on an empty left transmit queue sets its underrun flag
  a_r4_underrun_l: assert property (@(posedge clk) disable iff (!rstN)
    (ifEnable && serTxPop[0] && occ[0] == '0) |=> status[4]);

  // R5: serial push into a full right receive queue sets its overrun flag
  a_r5_overrun_r: assert property (@(posedge clk) disable iff (!rstN)
    (ifEnable && serRxPush[1] && occ[3] == CW'(DEPTH)) |=> status[7]);

  // R6: an error flag not being cleared stays set
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ((status[7:4] & ~errClear) != 4'b0) |=>
      ((status[7:4] & $past(status[7:4] & ~errClear)) == $past(status[7:4] & ~errClear)));

  // R7: any error flag raises the interrupt
  a_r7_err_irq: assert property (@(posedge clk) disable iff (!rstN)
    (status[7:4] != 4'b0) |-> irq);

  // R10: a disabled edge leaves every queue empty
  a_r10_flush: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |=> (occ == '0));

  // R11: no queue ever exceeds its depth
  a_r11_bound: assert property (@(posedge clk) disable iff (!rstN)
    (occ[0] <= CW'(DEPTH)) && (occ[1] <= CW'(DEPTH)) &&
    (occ[2] <= CW'(DEPTH)) && (occ[3] <= CW'(DEPTH)));
endmodule

bind audio_fifo_status audio_fifo_status_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ifEnable  (ifEnable),
  .serTxPop  (serTxPop),
  .serRxPush (serRxPush),
  .errClear  (errClear),
  .status    (status),
  .irq       (irq),
  .occ       (fifoCount)
);

// File: tb/audio_fifo_status_test.sv
`timescale 1ns/1ps
module audio_fifo_status_test;
  logic        clk = 0;
  logic        rstN, ifEnable;
  logic [1:0]  hostTxPush, hostRxPop, serTxPop, serRxPush;
  logic [31:0] hostTxData, serRxData, hostRxData, serTxData;
  logic [3:0]  maskBits, errClear;
  logic [11:0] status;
  logic        irq;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  audio_fifo_status uut (.*);

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hostPush(input int ch, input logic [15:0] d);
    @(negedge clk); hostTxPush[ch] = 1; hostTxData[ch*16 +: 16] = d;
    @(negedge clk); hostTxPush = 0; #1;
  endtask

  task automatic serPush(input int ch, input logic [15:0] d);
    @(negedge clk); serRxPush[ch] = 1; serRxData[ch*16 +: 16] = d;
    @(negedge clk); serRxPush = 0; #1;
  endtask

  task automatic serPop(input int ch, input logic [15:0] exp, input string tag);
    @(negedge clk); serTxPop[ch] = 1; #1;
    chkEq(tag, serTxData[ch*16 +: 16], exp);
    @(negedge clk); serTxPop = 0; #1;
  endtask

  task automatic hostPop(input int ch, input logic [15:0] exp, input string tag);
    @(negedge clk); hostRxPop[ch] = 1; #1;
    chkEq(tag, hostRxData[ch*16 +: 16], exp);
    @(negedge clk); hostRxPop = 0; #1;
  endtask

  task automatic pulseClear(input logic [3:0] bits);
    @(negedge clk); errClear = bits;
    @(negedge clk); errClear = 0; #1;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chkEq("R3/R8 reset status disabled", status, 12'h300);
    chkEq("R7 reset irq", irq, 0);
    ifEnable = 1; #1;
    chkEq("R2 empty tx requests when enabled", status, 12'h303);
  endtask

  task automatic t_tx();
    for (int i = 0; i < 4; i++) hostPush(0, 16'h1000 + 16'(i));
    chkEq("R2 tx left request at 4", status[0], 1);
    hostPush(0, 16'h1004);
    chkEq("R2 tx left request off at 5", status[0], 0);
    chkEq("R9 tx right untouched", status[1], 1);
    for (int i = 5; i < 12; i++) hostPush(0, 16'h1000 + 16'(i));
    chkEq("R8 tx left not-full low at 12", status[8], 0);
    hostPush(0, 16'hDEAD);
    for (int i = 0; i < 12; i++) serPop(0, 16'h1000 + 16'(i), "R11 tx order");
    chkEq("R8 tx left not-full after drain", status[8], 1);
    serPop(0, 16'h0000, "R4 underrun reads zero");
    chkEq("R4 underrun flag left", status[4], 1);
    chkEq("R9 underrun right clear", status[5], 0);
    chkEq("R7 error drives irq unmasked", irq, 1);
    serPop(0, 16'h0000, "R4 queue unchanged after underrun");
    pulseClear(4'b0001);
    chkEq("R6 clear underrun", status[4], 0);
    chkEq("R7 masked request no irq", irq, 0);
    maskBits = 4'b0001; #1;
    chkEq("R7 mask enables tx request irq", irq, 1);
    maskBits = 0; #1;
  endtask

  task automatic t_rx();
    for (int i = 0; i < 5; i++) serPush(1, 16'h2000 + 16'(i));
    chkEq("R1 rx right request off at 5", status[3], 0);
    chkEq("R8 rx right not-empty", status[11], 1);
    chkEq("R9 rx left still empty", status[10], 0);
    serPush(1, 16'h2005);
    chkEq("R1 rx right request at 6", status[3], 1);
    for (int i = 6; i < 12; i++) serPush(1, 16'h2000 + 16'(i));
    serPush(1, 16'hBEEF);
    chkEq("R5 overrun flag right", status[7:4], 4'b1000);
    for (int i = 0; i < 12; i++) hostPop(1, 16'h2000 + 16'(i), "R5/R11 rx order, extra dropped");
    hostPop(1, 16'h0000, "R11 empty host pop reads zero");
    chkEq("R11 empty host pop sets no flag", status[7:4], 4'b1000);
    chkEq("R8 rx right empty", status[11], 0);
    pulseClear(4'b1000);
    chkEq("R6 clear overrun", status[7:4], 4'b0000);
  endtask

  task automatic t_sticky();
    @(negedge clk); serTxPop[0] = 1; errClear = 4'b0001;
    @(negedge clk); serTxPop = 0; errClear = 0; #1;
    chkEq("R6 set wins over clear", status[4], 1);
    pulseClear(4'b0010);
    chkEq("R6 other clear bit leaves flag", status[4], 1);
    repeat (3) @(negedge clk); #1;
    chkEq("R6 flag sticky over idle cycles", status[4], 1);
    pulseClear(4'b0001);
    chkEq("R6 cleared", status[4], 0);
  endtask

  task automatic t_disable();
    for (int i = 0; i < 7; i++) serPush(0, 16'h3000 + 16'(i));
    chkEq("R1 rx left request at 7", status[2], 1);
    @(negedge clk); ifEnable = 0; #1;
    chkEq("R3 requests low when disabled", status[3:0], 4'b0);
    chkEq("R10 flush not before edge", status[10], 1);
    @(negedge clk); #1;
    chkEq("R10 flushed after edge", status[10], 0);
    for (int i = 0; i < 7; i++) serPush(0, 16'h4000);
    serPop(1, 16'h0000, "R10 disabled pop reads zero");
    chkEq("R10 no error while disabled", status[7:4], 4'b0);
    @(negedge clk); ifEnable = 1; #1;
    chkEq("R10 disabled pushes ignored", status, 12'h303);
  endtask

  initial begin
    rstN = 0; ifEnable = 0; hostTxPush = 0; hostRxPop = 0; serTxPop = 0;
    serRxPush = 0; hostTxData = 0; serRxData = 0; maskBits = 0; errClear = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_tx();
    t_rx();
    t_sticky();
    t_disable();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule